// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank State Tracker

This block sits on the command side of a DDR SDRAM device model. On every rising clock edge it samples chip select, the three command strobes, the two bank bits, the 14-bit address and the clock enable. It turns them into one of seven commands and tracks, for each of four banks, whether a row is open and which row it is. It also holds the mode and extended mode registers.

Address bit 10 has two roles. On a precharge it chooses between closing one bank and closing all banks. On a read or write it requests auto-precharge. The block also tracks how long a burst runs, using the burst-length field of the mode register. It reports when the clock enable is dropped while a burst is still running.

When the clock enable is sampled low, the block picks a power state from the bank state: precharge power-down, active power-down or self refresh. It leaves that state on the first edge where the clock enable is high again. The bank state survives power-down.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: When `cs_n` is sampled high, no bank, row or mode register changes, whatever the other strobes and the address show. `last_cmd` then reads 7.
- R2: With the block in normal state and `cke` high, `{cs_n,ras_n,cas_n,we_n}` decodes as follows: 0011 ACTIVE, 0101 READ, 0100 WRITE, 0010 PRECHARGE, 0001 REFRESH, 0000 LOAD MODE. Any other code with `cs_n` low is a NOP. `last_cmd` reports the command from the previous edge as NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, REFRESH=5, LOAD MODE=6, deselect=7.
- R3: ACTIVE to a closed bank sets `bank_open[ba]` and stores `addr` in `open_rows[ba*14 +: 14]`. ACTIVE to an open bank raises `proto_err` for one cycle and leaves the stored row unchanged.
- R4: PRECHARGE with `addr[10]`=0 closes only bank `ba`. With `addr[10]`=1 it closes all four banks.
- R5: READ or WRITE to a closed bank, and REFRESH while any bank is open, raise `proto_err` for exactly one cycle and change no bank state.
- R6: READ or WRITE with `addr[10]`=1 to an open bank clears that bank's open bit from the next cycle. With `addr[10]`=0 the bank stays open.
- R7: LOAD MODE with `ba`=0 writes `addr` into `mode_reg`. With `ba`=1 it writes `ext_mode_reg`. With `ba`=2 or 3 it changes neither register.
- R8: An accepted READ or WRITE holds `burst_busy` high for N cycles. N depends on `mode_reg[2:0]`: 1 cycle for code 001, 2 cycles for 010, 4 cycles for 011, and 1 cycle for any other code.
- R9: `cke` sampled low while `burst_busy` is high raises `cke_err` for one cycle. `cke` sampled low with no burst running leaves `cke_err` at 0.
- R10: In normal state, `cke` sampled low executes no command and sets `pwr_state`. The state is 2 (active power-down) if any bank is open. With all banks idle it is 3 (self refresh) when the code is REFRESH and 1 (precharge power-down) otherwise.
- R11: In states 1, 2 and 3, commands are ignored. The first edge with `cke` high returns `pwr_state` to 0 (normal) and also ignores its command. Bank state is kept throughout.
- R12: A synchronous reset closes all banks and clears both mode registers, the stored rows, the error flags and the burst. It sets `pwr_state` to 0 and `last_cmd` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 14 | Row/column address and op-code |
| bank_open | output | 4 | One open bit per bank |
| open_rows | output | 56 | Stored row per bank, bank b at bits b*14 +: 14 |
| mode_reg | output | 14 | Mode register |
| ext_mode_reg | output | 14 | Extended mode register |
| pwr_state | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down, 3 self refresh |
| last_cmd | output | 3 | Command decoded at the previous edge |
| burst_busy | output | 1 | A read or write burst is in progress |
| proto_err | output | 1 | One-cycle pulse on an illegal command |
| cke_err | output | 1 | One-cycle pulse on a clock-enable drop during a burst |

## Verification
The hardest case to reach is a clock-enable drop at a chosen point inside a burst. Reaching it requires a mode register load, then a bank activation, then an access, then a chosen number of idle cycles. The bench sweeps all three burst lengths and every drop offset from the access edge up to one past the burst. It alternates reads and writes, and it expects an error exactly when the drop lands inside the burst. Each case ends in active power-down, which also tests the exit path. It is followed by a precharge of all banks so that every case starts from the same idle state.

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker #(
  parameter int ROW_W = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [1:0]           ba,
  input  logic [ROW_W-1:0]     addr,
  output logic [3:0]           bank_open,
  output logic [4*ROW_W-1:0]   open_rows,
  output logic [ROW_W-1:0]     mode_reg,
  output logic [ROW_W-1:0]     ext_mode_reg,
  output logic [1:0]           pwr_state,
  output logic [2:0]           last_cmd,
  output logic                 burst_busy,
  output logic                 proto_err,
  output logic                 cke_err
);
  localparam logic [1:0] PS_NORM = 2'd0, PS_PPD = 2'd1, PS_APD = 2'd2, PS_SR = 2'd3;
  localparam logic [3:0] K_ACT = 4'b0011, K_RD = 4'b0101, K_WR = 4'b0100,
                         K_PRE = 4'b0010, K_REF = 4'b0001, K_LMR = 4'b0000;

  logic [3:0] code;
  logic [2:0] burst_left, burst_len;
  logic       hit, any_open, auto_pre;

  assign code       = {cs_n, ras_n, cas_n, we_n};
  assign hit        = bank_open[ba];
  assign any_open   = |bank_open;
  assign auto_pre   = addr[10];
  assign burst_busy = burst_left != 3'd0;

  always_comb begin
    case (mode_reg[2:0])
      3'b010:  burst_len = 3'd2;
      3'b011:  burst_len = 3'd4;
      default: burst_len = 3'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_open    <= '0;
      open_rows    <= '0;
      mode_reg     <= '0;
      ext_mode_reg <= '0;
      pwr_state    <= PS_NORM;
      last_cmd     <= 3'd0;
      burst_left   <= '0;
      proto_err    <= 1'b0;
      cke_err      <= 1'b0;
    end else begin
      proto_err <= 1'b0;
      cke_err   <= 1'b0;
      last_cmd  <= 3'd0;
      if (burst_busy) burst_left <= burst_left - 3'd1;
      if (pwr_state != PS_NORM) begin
        if (cke) pwr_state <= PS_NORM;
      end else if (!cke) begin
        if (burst_busy) cke_err <= 1'b1;
        if (any_open)            pwr_state <= PS_APD;
        else if (code == K_REF)  pwr_state <= PS_SR;
        else                     pwr_state <= PS_PPD;
      end else if (cs_n) begin
        last_cmd <= 3'd7;
      end else begin
        case (code)
          K_ACT: begin
            last_cmd <= 3'd1;
            if (hit) proto_err <= 1'b1;
            else begin
              bank_open[ba] <= 1'b1;
              open_rows[int'(ba)*ROW_W +: ROW_W] <= addr;
            end
          end
          K_RD, K_WR: begin
            last_cmd <= (code == K_RD) ? 3'd2 : 3'd3;
            if (!hit) proto_err <= 1'b1;
            else begin
              burst_left <= burst_len;
              if (auto_pre) bank_open[ba] <= 1'b0;
            end
          end
          K_PRE: begin
            last_cmd <= 3'd4;
            if (auto_pre) bank_open <= '0;
            else          bank_open[ba] <= 1'b0;
          end
          K_REF: begin
            last_cmd <= 3'd5;
            if (any_open) proto_err <= 1'b1;
          end
          K_LMR: begin
            last_cmd <= 3'd6;
            if (ba == 2'd0) mode_reg <= addr;
            if (ba == 2'd1) ext_mode_reg <= addr;
          end
          default: last_cmd <= 3'd0;
        endcase
      end
    end
  end
endmodule

module ddr_cmd_tracker_chk (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [1:0] ba,
  input logic [13:0] addr,
  input logic [3:0] bank_open,
  input logic [1:0] pwr_state,
  input logic       burst_busy,
  input logic       proto_err,
  input logic       cke_err
);
  p_desel_keeps_banks_r1: assert property (@(posedge clk) disable iff (rst)
    (cs_n && cke && pwr_state == 2'd0) |=> $stable(bank_open));
  p_act_opens_r3: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd0 && cke && {cs_n, ras_n, cas_n, we_n} == 4'b0011 && !bank_open[ba])
      |=> bank_open[$past(ba)]);
  p_pre_all_r4: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd0 && cke && {cs_n, ras_n, cas_n, we_n} == 4'b0010 && addr[10])
      |=> bank_open == 4'd0);
  p_err_no_change_r5: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $stable(bank_open));
  p_cke_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
    cke_err |-> ($past(!cke) && $past(burst_busy)));
  p_sr_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd3) |-> bank_open == 4'd0);
  p_pd_retains_r11: assert property (@(posedge clk) disable iff (rst)
    (pwr_state != 2'd0) |=> $stable(bank_open));
endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .addr(addr), .bank_open(bank_open), .pwr_state(pwr_state),
  .burst_busy(burst_busy), .proto_err(proto_err), .cke_err(cke_err)
);

// File: tb/ddr_cmd_tracker_test.sv
`timescale 1ns/1ps
module ddr_cmd_tracker_test;
  logic clk = 0, rst = 1, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0] ba = 0;
  logic [13:0] addr = 0;
  logic [3:0] bank_open;
  logic [55:0] open_rows;
  logic [13:0] mode_reg, ext_mode_reg;
  logic [1:0] pwr_state;
  logic [2:0] last_cmd;
  logic burst_busy, proto_err, cke_err;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;

  always #2.5 clk = ~clk;

  ddr_cmd_tracker uut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .bank_open(bank_open), .open_rows(open_rows),
    .mode_reg(mode_reg), .ext_mode_reg(ext_mode_reg), .pwr_state(pwr_state),
    .last_cmd(last_cmd), .burst_busy(burst_busy), .proto_err(proto_err), .cke_err(cke_err)
  );

  task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic [13:0] a, input logic k);
    {cs_n, ras_n, cas_n, we_n} = c; ba = b; addr = a; cke = k;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int row_of(input int b);
    return int'(open_rows[b*14 +: 14]);
  endfunction

  initial begin
    #900000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    issue(NOP, 0, 0, 1); issue(NOP, 0, 0, 1);
    rst = 0;
    // R12 reset state
    chk("R12 bank_open", bank_open, 0);
    chk("R12 pwr_state", pwr_state, 0);
    chk("R12 mode_reg", mode_reg, 0);
    chk("R12 ext_mode_reg", ext_mode_reg, 0);
    chk("R12 last_cmd", last_cmd, 0);
    chk("R12 rows", row_of(3), 0);

    // R3 open every bank with a computed row
    for (int b = 0; b < 4; b++) begin
      issue(ACT, b[1:0], 14'(b * 4099 + 17), 1);
      chk("R3 open bit", bank_open[b], 1);
      chk("R3 row", row_of(b), b * 4099 + 17);
      chk("R2 last_cmd act", last_cmd, 1);
    end

    // R1 every code with chip select high, every bank
    for (int c = 8; c < 16; c++)
      for (int b = 0; b < 4; b++) begin
        issue(4'(c), b[1:0], 14'h3fff, 1);
        chk("R1 banks", bank_open, 15);
        chk("R1 row", row_of(b), b * 4099 + 17);
        chk("R1 mode", mode_reg, 0);
        chk("R1 last_cmd", last_cmd, 7);
      end

    // R3 activate to open bank
    issue(ACT, 2, 14'h0123, 1);
    chk("R3 err", proto_err, 1);
    chk("R3 row kept", row_of(2), 2 * 4099 + 17);
    issue(NOP, 0, 0, 1);
    chk("R3 err one cycle", proto_err, 0);
    chk("R2 last_cmd nop", last_cmd, 0);

    // R5 refresh with banks open
    issue(REF, 0, 0, 1);
    chk("R5 refresh err", proto_err, 1);
    chk("R2 last_cmd ref", last_cmd, 5);
    chk("R5 banks kept", bank_open, 15);

    // R4 single precharge
    issue(PRE, 1, 0, 1);
    chk("R4 single", bank_open, 4'b1101);
    chk("R2 last_cmd pre", last_cmd, 4);
    issue(PRE, 3, 0, 1);
    chk("R4 single b3", bank_open, 4'b0101);
    issue(PRE, 0, 14'h0400, 1);
    chk("R4 all", bank_open, 0);

    // R5 access to closed banks
    for (int b = 0; b < 4; b++) begin
      issue((b % 2) ? WR : RD, b[1:0], 0, 1);
      chk("R5 closed access err", proto_err, 1);
      chk("R5 no burst", burst_busy, 0);
      chk("R2 last_cmd rw", last_cmd, (b % 2) ? 3 : 2);
    end
    issue(NOP, 0, 0, 1);
    chk("R5 err cleared", proto_err, 0);

    // R7 mode loads
    issue(LMR, 0, 14'h0032, 1);
    chk("R7 mode", mode_reg, 14'h0032);
    chk("R2 last_cmd lmr", last_cmd, 6);
    issue(LMR, 1, 14'h0005, 1);
    chk("R7 ext", ext_mode_reg, 5);
    chk("R7 mode kept", mode_reg, 14'h0032);
    for (int b = 2; b < 4; b++) begin
      issue(LMR, b[1:0], 14'h3fff, 1);
      chk("R7 mode untouched", mode_reg, 14'h0032);
      chk("R7 ext untouched", ext_mode_reg, 5);
    end

    // R8 R9 burst length and drop offset sweep
    for (int code = 1; code <= 3; code++) begin
      int cyc;
      cyc = 1 << (code - 1);
      for (int d = 0; d <= cyc; d++) begin
        issue(LMR, 0, 14'(code), 1);
        issue(ACT, 0, 14'h0a5a, 1);
        issue((d % 2) ? WR : RD, 0, 0, 1);
        chk("R8 busy after access", burst_busy, 1);
        chk("R6 no auto keeps open", bank_open[0], 1);
        for (int i = 0; i < d; i++) begin
          issue(NOP, 0, 0, 1);
          chk("R8 busy window", burst_busy, (i + 1 < cyc) ? 1 : 0);
        end
        issue(NOP, 0, 0, 0);
        chk("R9 cke drop", cke_err, (d < cyc) ? 1 : 0);
        chk("R10 active pd", pwr_state, 2);
        issue(NOP, 0, 0, 1);
        chk("R9 one cycle", cke_err, 0);
        chk("R11 exit", pwr_state, 0);
        issue(PRE, 0, 14'h0400, 1);
      end
    end
    issue(NOP, 0, 0, 1); issue(NOP, 0, 0, 1); issue(NOP, 0, 0, 1); issue(NOP, 0, 0, 1);
    issue(NOP, 0, 0, 0);
    chk("R9 no burst no err", cke_err, 0);
    issue(NOP, 0, 0, 1);

    // R6 auto-precharge
    issue(ACT, 1, 14'h0077, 1);
    issue(RD, 1, 14'h0400, 1);
    chk("R6 auto closes", bank_open[1], 0);
    chk("R8 auto busy", burst_busy, 1);
    issue(WR, 1, 0, 1);
    chk("R6 closed after auto", proto_err, 1);

    // R10 R11 power states
    issue(NOP, 0, 0, 0);
    chk("R10 precharge pd", pwr_state, 1);
    issue(ACT, 2, 14'h0011, 0);
    chk("R11 ignored in pd", bank_open, 0);
    issue(ACT, 2, 14'h0011, 1);
    chk("R11 exit to normal", pwr_state, 0);
    chk("R11 exit edge ignores cmd", bank_open, 0);
    issue(REF, 0, 0, 0);
    chk("R10 self refresh", pwr_state, 3);
    issue(NOP, 0, 0, 0);
    chk("R11 stays sr", pwr_state, 3);
    issue(NOP, 0, 0, 1);
    chk("R11 sr exit", pwr_state, 0);
    issue(REF, 0, 0, 1);
    chk("R5 idle refresh ok", proto_err, 0);
    issue(ACT, 2, 14'h0222, 1);
    issue(REF, 0, 0, 0);
    chk("R10 open gives active pd", pwr_state, 2);
    issue(PRE, 2, 0, 0);
    chk("R11 bank kept in pd", bank_open, 4'b0100);
    issue(NOP, 0, 0, 1);
    chk("R11 apd exit", pwr_state, 0);
    chk("R11 row kept", row_of(2), 14'h0222);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule